// File: doc/BRIEF.md
# Multicore Boot Release Mailbox

This block is a memory-mapped slave that parks every secondary core of a multicore system until firmware hands it a place to start. Each core owns a 32-byte record. The primary core or boot firmware fills in a 64-bit start address and a 64-bit argument for a waiting core. It then clears bit 0 of that start address, which serves as a hold flag. Once the flag is clear, the block emits a single-cycle launch pulse carrying the core number and the launch parameters. The start address is split into a window base aligned to 64 MiB and an entry offset inside that window. The outputs also carry the argument and the mapping size.

Storage is one dual-port memory of 32-bit words, so it can map onto block RAM. The bus side uses port A. The other port is used by a small sequencer. After reset the sequencer writes the reset image into every record, and after each release it gathers the launch parameters. It also writes the core's hardware ID into the record's identity field. All multi-byte fields are big-endian, and the bus accepts naturally aligned byte, halfword and word accesses.

Top module: `boot_release_mbox`

## Requirements
- R1: After reset, `mbox_ready` stays low while the reset image is written and then rises for good. From then on every record r holds: start address (bytes 0..7) = 1, argument (bytes 8..15) = r, reserved word (bytes 16..19) = 0, core ID (bytes 20..23) = r, and the last reserved field (bytes 24..31) = 0. A request made while `mbox_ready` is low gets an error response.
- R2: A read of size 1, 2 or 4 bytes at byte offset a returns, right-aligned in `bus_rdata`, the bytes a, a+1, ... with byte a as the most significant. Byte offset a belongs to record a/32.
- R3: A legal write of size 1, 2 or 4 stores the low bytes of `bus_wdata` in the same big-endian order and leaves every other byte unchanged.
- R4: A write to record 0, or to a record whose index is at or above `CORES`, changes nothing and triggers no launch. It still gets a response without error, and reads of those records still return their stored contents.
- R5: A request with a size other than 1, 2 or 4, or with an address that is not a multiple of its size, gets `bus_err` = 1. It changes no storage and triggers no launch.
- R6: After an accepted write, if bit 0 of byte 7 of the record (the hold flag) is 0, then `launch_valid` pulses high for exactly one cycle with `launch_core` equal to the record index.
- R7: During the pulse, `launch_entry` carries the low 26 bits of the start address. `launch_window` carries the start address with those 26 bits cleared. `launch_arg` carries the argument and `launch_map_size` carries 64 MiB (0x400_0000).
- R8: On release, the record's core ID field (bytes 20..23) is overwritten with that core's 32-bit slice of `core_hwid` (bits 32r+31..32r).
- R9: Each core launches at most once per reset. Later writes, including ones that set and clear the hold flag again, produce no pulse. A reset re-arms every core.
- R10: Every accepted request receives exactly one response: `bus_rvalid` high on the second rising edge after the edge that sampled the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Request strobe, one cycle per request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (10) | Byte offset within the mailbox |
| bus_size | input | 3 | Access size in bytes |
| bus_wdata | input | 32 | Write value, right-aligned |
| bus_rvalid | output | 1 | Response strobe |
| bus_err | output | 1 | Error response |
| bus_rdata | output | 32 | Read value, right-aligned |
| mbox_ready | output | 1 | Reset image written, requests accepted |
| core_hwid | input | NUM_REC*32 | Hardware ID of each core, 32 bits per core |
| launch_valid | output | 1 | One-cycle release pulse |
| launch_core | output | RIW (5) | Released core index |
| launch_entry | output | 64 | Entry offset inside the window |
| launch_window | output | 64 | 64 MiB aligned window base |
| launch_arg | output | 64 | Argument for the released core |
| launch_map_size | output | 64 | Mapping size (64 MiB) |

## Verification
A response is due on the second rising edge after the edge that samples the request. The bench drives each request on a falling edge and removes it at the next falling edge. It checks that `bus_rvalid` is still low at that point and samples the response one falling edge later. A launch needs five sequencer cycles after the write edge, so every write is followed by a twelve-cycle window in which the bench counts pulses and captures their payload. Only after that window does the bench read the core ID field back.

// File: rtl/brm_pkg.sv
package brm_pkg;

  localparam int REC_BYTES     = 32;
  localparam int WORDS_PER_REC = 8;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_RD0,
    SQ_RD1,
    SQ_RD2,
    SQ_RD3,
    SQ_FIN
  } seq_state_e;

  // size legal and naturally aligned
  function automatic logic size_legal(input logic [2:0] sz, input logic [1:0] lo);
    case (sz)
      3'd1:    return 1'b1;
      3'd2:    return ~lo[0];
      3'd4:    return (lo == 2'b00);
      default: return 1'b0;
    endcase
  endfunction

  // byte offset L in a word sits in lane 3-L (big-endian)
  function automatic logic [3:0] lane_mask(input logic [2:0] sz, input logic [1:0] lo);
    case (sz)
      3'd1:    return 4'b1000 >> lo;
      3'd2:    return lo[1] ? 4'b0011 : 4'b1100;
      3'd4:    return 4'b1111;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic [31:0] lane_place(input logic [2:0] sz, input logic [31:0] wd);
    case (sz)
      3'd1:    return {4{wd[7:0]}};
      3'd2:    return {2{wd[15:0]}};
      default: return wd;
    endcase
  endfunction

  function automatic logic [31:0] lane_pick(input logic [2:0] sz, input logic [1:0] lo,
                                            input logic [31:0] q);
    logic [31:0] sh;
    case (sz)
      3'd1: begin
        sh = q >> (8 * (3 - int'(lo)));
        return {24'd0, sh[7:0]};
      end
      3'd2: begin
        sh = lo[1] ? q : (q >> 16);
        return {16'd0, sh[15:0]};
      end
      default: return q;
    endcase
  endfunction

  // reset image: word 1 = hold flag, word 3 = argument low, word 5 = core id
  function automatic logic [31:0] reset_word(input logic [31:0] rec, input logic [2:0] k);
    case (k)
      3'd1:    return 32'd1;
      3'd3:    return rec;
      3'd5:    return rec;
      default: return 32'd0;
    endcase
  endfunction

endpackage

// File: rtl/brm_ram.sv
module brm_ram #(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          a_en,
  input  logic [3:0]    a_be,
  input  logic [AW-1:0] a_addr,
  input  logic [31:0]   a_wdata,
  output logic [31:0]   a_q,
  input  logic          b_en,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [31:0]   b_wdata,
  output logic [31:0]   b_q
);

  logic [31:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_en) begin
      for (int l = 0; l < 4; l++) begin
        if (a_be[l]) mem[a_addr][8*l +: 8] <= a_wdata[8*l +: 8];
      end
      a_q <= mem[a_addr];
    end
    if (b_en) begin
      if (b_we) mem[b_addr] <= b_wdata;
      b_q <= mem[b_addr];
    end
  end

endmodule

// File: rtl/brm_bus_port.sv
module brm_bus_port
  import brm_pkg::*;
#(
  parameter int NUM_REC = 32,
  parameter int CORES   = 4,
  parameter int RIW     = $clog2(NUM_REC),
  parameter int WAW     = RIW + 3,
  parameter int AW      = WAW + 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ready,
  input  logic           bus_valid,
  input  logic           bus_write,
  input  logic [AW-1:0]  bus_addr,
  input  logic [2:0]     bus_size,
  input  logic [31:0]    bus_wdata,
  output logic           bus_rvalid,
  output logic           bus_err,
  output logic [31:0]    bus_rdata,
  output logic           a_en,
  output logic [3:0]     a_be,
  output logic [WAW-1:0] a_addr,
  output logic [31:0]    a_wdata,
  input  logic [31:0]    a_q,
  output logic           wr_accept,
  output logic [RIW-1:0] wr_rec,
  output logic           hold_touch,
  output logic           hold_bit
);

  logic       req_ok;
  logic       rec_live;
  logic [3:0] mask;
  logic       s1_v, s1_err, s1_rd;
  logic [2:0] s1_size;
  logic [1:0] s1_lo;

  assign wr_rec   = bus_addr[AW-1:5];
  assign rec_live = (wr_rec != '0) && (int'(wr_rec) < CORES);
  assign req_ok   = bus_valid && ready && size_legal(bus_size, bus_addr[1:0]);
  assign mask     = lane_mask(bus_size, bus_addr[1:0]);

  assign a_en    = req_ok;
  assign a_addr  = bus_addr[AW-1:2];
  assign a_wdata = lane_place(bus_size, bus_wdata);
  assign a_be    = (bus_write && rec_live) ? mask : 4'b0000;

  assign wr_accept  = req_ok && bus_write && rec_live;
  // byte 7 of a record is word 1, lane 0; its bit 0 is always wdata[0]
  assign hold_touch = wr_accept && (bus_addr[4:2] == 3'd1) && mask[0];
  assign hold_bit   = bus_wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v    <= 1'b0;
      s1_err  <= 1'b0;
      s1_rd   <= 1'b0;
      s1_size <= 3'd0;
      s1_lo   <= 2'd0;
    end else begin
      s1_v    <= bus_valid;
      s1_err  <= bus_valid && !req_ok;
      s1_rd   <= bus_valid && !bus_write;
      s1_size <= bus_size;
      s1_lo   <= bus_addr[1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      bus_err    <= 1'b0;
      bus_rdata  <= 32'd0;
    end else begin
      bus_rvalid <= s1_v;
      bus_err    <= s1_v && s1_err;
      bus_rdata  <= (s1_v && s1_rd && !s1_err) ? lane_pick(s1_size, s1_lo, a_q) : 32'd0;
    end
  end

  // R5
  bad_req_err_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !req_ok) |=> ##1 (bus_rvalid && bus_err));

  // R10
  resp_latency_chk: assert property (@(posedge clk) disable iff (rst)
    bus_valid |=> ##1 bus_rvalid);

  // R4
  boot_core_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && bus_addr[AW-1:5] == '0) |-> (a_be == 4'b0000));

endmodule

// File: rtl/brm_launch_seq.sv
module brm_launch_seq
  import brm_pkg::*;
#(
  parameter int NUM_REC   = 32,
  parameter int CORES     = 4,
  parameter int MAP_SHIFT = 26,
  parameter int RIW       = $clog2(NUM_REC),
  parameter int WAW       = RIW + 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_accept,
  input  logic [RIW-1:0]       wr_rec,
  input  logic                 hold_touch,
  input  logic                 hold_bit,
  input  logic [NUM_REC*32-1:0] core_hwid,
  output logic                 b_en,
  output logic                 b_we,
  output logic [WAW-1:0]       b_addr,
  output logic [31:0]          b_wdata,
  input  logic [31:0]          b_q,
  output logic                 ready,
  output logic                 launch_valid,
  output logic [RIW-1:0]       launch_core,
  output logic [63:0]          launch_entry,
  output logic [63:0]          launch_window,
  output logic [63:0]          launch_arg,
  output logic [63:0]          launch_map_size
);

  localparam int          DEPTH    = NUM_REC * WORDS_PER_REC;
  localparam logic [63:0] MAP_SIZE = 64'd1 << MAP_SHIFT;
  localparam logic [63:0] LOW_MASK = MAP_SIZE - 64'd1;

  seq_state_e         state;
  logic               init_busy;
  logic [WAW-1:0]     init_idx;
  logic [NUM_REC-1:0] hold_q, released, pending;
  logic [RIW-1:0]     cur;
  logic [31:0]        addr_hi, addr_lo, arg_hi;
  logic [RIW-1:0]     pick_idx;
  logic               pick_any;
  logic               hold_new;
  logic [2:0]         step;
  logic [63:0]        start_addr;

  // lowest pending core wins
  always_comb begin
    pick_idx = '0;
    pick_any = 1'b0;
    for (int i = NUM_REC - 1; i >= 0; i--) begin
      if (pending[i]) begin
        pick_any = 1'b1;
        pick_idx = RIW'(i);
      end
    end
  end

  assign hold_new = hold_touch ? hold_bit : hold_q[wr_rec];

  always_comb begin
    case (state)
      SQ_RD1:  step = 3'd1;
      SQ_RD2:  step = 3'd2;
      SQ_RD3:  step = 3'd3;
      SQ_FIN:  step = 3'd5;
      default: step = 3'd0;
    endcase
  end

  always_comb begin
    if (init_busy) begin
      b_en    = 1'b1;
      b_we    = 1'b1;
      b_addr  = init_idx;
      b_wdata = reset_word(32'(init_idx[WAW-1:3]), init_idx[2:0]);
    end else begin
      b_en    = (state != SQ_IDLE);
      b_we    = (state == SQ_FIN);
      b_addr  = {cur, step};
      b_wdata = core_hwid[32*int'(cur) +: 32];
    end
  end

  assign start_addr = {addr_hi, addr_lo};

  // reset image fill
  always_ff @(posedge clk) begin
    if (rst) begin
      init_busy <= 1'b1;
      init_idx  <= '0;
      ready     <= 1'b0;
    end else if (init_busy) begin
      init_idx <= init_idx + 1'b1;
      if (int'(init_idx) == DEPTH - 1) begin
        init_busy <= 1'b0;
        ready     <= 1'b1;
      end
    end
  end

  // hold shadow, sticky release, pending set
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q   <= '1;
      released <= '0;
      pending  <= '0;
    end else begin
      logic [NUM_REC-1:0] pend_n;
      pend_n = pending;
      if (state == SQ_IDLE && pick_any && ready) pend_n[pick_idx] = 1'b0;
      if (wr_accept) begin
        hold_q[wr_rec] <= hold_new;
        if (!hold_new && !released[wr_rec]) begin
          released[wr_rec] <= 1'b1;
          pend_n[wr_rec]   = 1'b1;
        end
      end
      pending <= pend_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state           <= SQ_IDLE;
      cur             <= '0;
      addr_hi         <= 32'd0;
      addr_lo         <= 32'd0;
      arg_hi          <= 32'd0;
      launch_valid    <= 1'b0;
      launch_core     <= '0;
      launch_entry    <= 64'd0;
      launch_window   <= 64'd0;
      launch_arg      <= 64'd0;
      launch_map_size <= 64'd0;
    end else begin
      launch_valid <= 1'b0;
      case (state)
        SQ_IDLE: if (ready && pick_any) begin
          cur   <= pick_idx;
          state <= SQ_RD0;
        end
        SQ_RD0: state <= SQ_RD1;
        SQ_RD1: begin
          addr_hi <= b_q;
          state   <= SQ_RD2;
        end
        SQ_RD2: begin
          addr_lo <= b_q;
          state   <= SQ_RD3;
        end
        SQ_RD3: begin
          arg_hi <= b_q;
          state  <= SQ_FIN;
        end
        SQ_FIN: begin
          launch_valid    <= 1'b1;
          launch_core     <= cur;
          launch_entry    <= start_addr & LOW_MASK;
          launch_window   <= start_addr & ~LOW_MASK;
          launch_arg      <= {arg_hi, b_q};
          launch_map_size <= MAP_SIZE;
          state           <= SQ_IDLE;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  // R6
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    launch_valid |=> !launch_valid);

  // R6
  launch_owner_chk: assert property (@(posedge clk) disable iff (rst)
    launch_valid |-> released[launch_core]);

  // R9
  sticky_release_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(released) >= $past($countones(released)));

  // R4
  boot_core_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !pending[0] && !released[0]);

  // R1
  ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready);

  // R1
  no_launch_in_fill_chk: assert property (@(posedge clk) disable iff (rst)
    !ready |-> !launch_valid);

endmodule

// File: rtl/boot_release_mbox.sv
module boot_release_mbox
  import brm_pkg::*;
#(
  parameter int NUM_REC   = 32,
  parameter int CORES     = 4,
  parameter int MAP_SHIFT = 26,
  parameter int RIW       = $clog2(NUM_REC),
  parameter int AW        = RIW + 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_valid,
  input  logic                  bus_write,
  input  logic [AW-1:0]         bus_addr,
  input  logic [2:0]            bus_size,
  input  logic [31:0]           bus_wdata,
  output logic                  bus_rvalid,
  output logic                  bus_err,
  output logic [31:0]           bus_rdata,
  output logic                  mbox_ready,
  input  logic [NUM_REC*32-1:0] core_hwid,
  output logic                  launch_valid,
  output logic [RIW-1:0]        launch_core,
  output logic [63:0]           launch_entry,
  output logic [63:0]           launch_window,
  output logic [63:0]           launch_arg,
  output logic [63:0]           launch_map_size
);

  localparam int WAW   = RIW + 3;
  localparam int DEPTH = NUM_REC * WORDS_PER_REC;

  logic           a_en, b_en, b_we;
  logic [3:0]     a_be;
  logic [WAW-1:0] a_addr, b_addr;
  logic [31:0]    a_wdata, a_q, b_wdata, b_q;
  logic           wr_accept, hold_touch, hold_bit;
  logic [RIW-1:0] wr_rec;

  brm_bus_port #(
    .NUM_REC(NUM_REC), .CORES(CORES), .RIW(RIW), .WAW(WAW), .AW(AW)
  ) u_bus (
    .clk(clk), .rst(rst), .ready(mbox_ready),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rvalid(bus_rvalid), .bus_err(bus_err), .bus_rdata(bus_rdata),
    .a_en(a_en), .a_be(a_be), .a_addr(a_addr), .a_wdata(a_wdata), .a_q(a_q),
    .wr_accept(wr_accept), .wr_rec(wr_rec),
    .hold_touch(hold_touch), .hold_bit(hold_bit)
  );

  brm_launch_seq #(
    .NUM_REC(NUM_REC), .CORES(CORES), .MAP_SHIFT(MAP_SHIFT), .RIW(RIW), .WAW(WAW)
  ) u_seq (
    .clk(clk), .rst(rst),
    .wr_accept(wr_accept), .wr_rec(wr_rec),
    .hold_touch(hold_touch), .hold_bit(hold_bit),
    .core_hwid(core_hwid),
    .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_q(b_q),
    .ready(mbox_ready),
    .launch_valid(launch_valid), .launch_core(launch_core),
    .launch_entry(launch_entry), .launch_window(launch_window),
    .launch_arg(launch_arg), .launch_map_size(launch_map_size)
  );

  brm_ram #(.DEPTH(DEPTH), .AW(WAW)) u_ram (
    .clk(clk),
    .a_en(a_en), .a_be(a_be), .a_addr(a_addr), .a_wdata(a_wdata), .a_q(a_q),
    .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_q(b_q)
  );

endmodule

// File: tb/tb_boot_release_mbox.sv
`timescale 1ns/1ps
module tb_boot_release_mbox;
  localparam int NREC  = 32;
  localparam int NCORE = 4;
  localparam int AW    = 10;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic               rst = 1'b1;
  logic               bus_valid = 1'b0, bus_write = 1'b0;
  logic [AW-1:0]      bus_addr = '0;
  logic [2:0]         bus_size = 3'd0;
  logic [31:0]        bus_wdata = 32'd0;
  logic               bus_rvalid, bus_err, mbox_ready;
  logic [31:0]        bus_rdata;
  logic [NREC*32-1:0] core_hwid;
  logic               launch_valid;
  logic [4:0]         launch_core;
  logic [63:0]        launch_entry, launch_window, launch_arg, launch_map_size;

  boot_release_mbox #(.NUM_REC(NREC), .CORES(NCORE), .MAP_SHIFT(26)) dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rvalid(bus_rvalid), .bus_err(bus_err), .bus_rdata(bus_rdata),
    .mbox_ready(mbox_ready), .core_hwid(core_hwid),
    .launch_valid(launch_valid), .launch_core(launch_core),
    .launch_entry(launch_entry), .launch_window(launch_window),
    .launch_arg(launch_arg), .launch_map_size(launch_map_size)
  );

  int          n_run = 0, n_fail = 0;
  logic [7:0]  model [NREC*32];
  int          pulses = 0;
  logic [4:0]  p_core;
  logic [63:0] p_entry, p_window, p_arg, p_size;

  initial begin
    for (int i = 0; i < NREC; i++) core_hwid[32*i +: 32] = 32'hC0DE_0000 + 32'(i * 7);
  end

  always @(negedge clk) begin
    if (!rst && launch_valid) begin
      pulses   = pulses + 1;
      p_core   = launch_core;
      p_entry  = launch_entry;
      p_window = launch_window;
      p_arg    = launch_arg;
      p_size   = launch_map_size;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int r = 0; r < NREC; r++) begin
      for (int b = 0; b < 32; b++) model[r*32+b] = 8'd0;
      model[r*32+7] = 8'd1;
      model[r*32+15] = 8'(r);
      model[r*32+23] = 8'(r);
    end
  endtask

  function automatic logic [63:0] model_rd(input int addr, input int sz);
    logic [63:0] v = 64'd0;
    for (int i = 0; i < sz; i++) v = (v << 8) | 64'(model[addr+i]);
    return v;
  endfunction

  task automatic model_wr(input int addr, input int sz, input logic [31:0] d);
    for (int i = 0; i < sz; i++) model[addr+i] = 8'(d >> (8 * (sz - 1 - i)));
  endtask

  task automatic bus(input bit wr, input int addr, input int sz, input logic [31:0] wd,
                     output logic [31:0] rd, output logic err);
    logic early;
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = AW'(addr);
    bus_size = 3'(sz); bus_wdata = wd;
    @(negedge clk);
    bus_valid = 1'b0;
    early = bus_rvalid;
    @(negedge clk);
    rd  = bus_rdata;
    err = bus_err;
    chk(!early && bus_rvalid, "R10 response on second edge", {63'd0, bus_rvalid}, 64'd1);
  endtask

  task automatic do_reset();
    int w;
    @(negedge clk);
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!mbox_ready, "R1 ready low during fill", {63'd0, mbox_ready}, 64'd0);
    w = 0;
    while (!mbox_ready && w < 1000) begin
      @(negedge clk);
      w++;
    end
    chk(mbox_ready, "R1 ready after fill", {63'd0, mbox_ready}, 64'd1);
    model_reset();
  endtask

  // write, then watch for a launch; exp_rel says whether one is due
  task automatic wr_watch(input int addr, input int sz, input logic [31:0] d,
                          input bit exp_rel, input string tag);
    logic [31:0] rd;
    logic        err;
    logic [63:0] a, g;
    int          rec;
    rec = addr / 32;
    pulses = 0;
    bus(1'b1, addr, sz, d, rd, err);
    if (rec >= 1 && rec < NCORE) model_wr(addr, sz, d);
    repeat (12) @(negedge clk);
    if (!exp_rel) begin
      chk(pulses == 0, {tag, " no launch"}, 64'(pulses), 64'd0);
    end else begin
      a = model_rd(rec*32, 8);
      g = model_rd(rec*32 + 8, 8);
      chk(pulses == 1, "R6 single launch pulse", 64'(pulses), 64'd1);
      chk(p_core == 5'(rec), "R6 launch core", 64'(p_core), 64'(rec));
      chk(p_entry == (a & 64'h3FF_FFFF), "R7 entry offset", p_entry, a & 64'h3FF_FFFF);
      chk(p_window == (a & ~64'h3FF_FFFF), "R7 window base", p_window, a & ~64'h3FF_FFFF);
      chk(p_arg == g, "R7 argument", p_arg, g);
      chk(p_size == 64'h400_0000, "R7 map size", p_size, 64'h400_0000);
      model_wr(rec*32 + 20, 4, core_hwid[32*rec +: 32]);
      bus(1'b0, rec*32 + 20, 4, 32'd0, rd, err);
      chk(rd == model_rd(rec*32 + 20, 4), "R8 core id overwritten", 64'(rd), model_rd(rec*32 + 20, 4));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic        err;
    logic [31:0] d;
    int          base;

    do_reset();

    // R1: full reset image
    for (int w = 0; w < NREC*8; w++) begin
      bus(1'b0, w*4, 4, 32'd0, rd, err);
      chk(rd == model_rd(w*4, 4) && !err, "R1 reset word", 64'(rd), model_rd(w*4, 4));
    end

    // R2: byte and halfword reads, big-endian
    for (int a = 0; a < 128; a++) begin
      bus(1'b0, a, 1, 32'd0, rd, err);
      chk(rd == model_rd(a, 1), "R2 byte read", 64'(rd), model_rd(a, 1));
      if (a % 2 == 0) begin
        bus(1'b0, a, 2, 32'd0, rd, err);
        chk(rd == model_rd(a, 2), "R2 halfword read", 64'(rd), model_rd(a, 2));
      end
    end

    // R3: write sweep over record 2, hold flag kept set
    base = 2 * 32;
    for (int s = 0; s < 3; s++) begin
      int sz;
      sz = (s == 0) ? 1 : (s == 1) ? 2 : 4;
      for (int off = 0; off < 32; off += sz) begin
        d = 32'(off * 37 + sz * 11 + 90) * 32'h0101_0101;
        if (off <= 7 && off + sz > 7) d[0] = 1'b1;
        wr_watch(base + off, sz, d, 1'b0, "R3");
        bus(1'b0, base + (off & ~3), 4, 32'd0, rd, err);
        chk(rd == model_rd(base + (off & ~3), 4), "R3 write merge", 64'(rd), model_rd(base + (off & ~3), 4));
      end
    end

    // R4: boot core and absent cores ignore writes
    for (int k = 0; k < 3; k++) begin
      int r;
      r = (k == 0) ? 0 : (k == 1) ? 5 : 31;
      pulses = 0;
      bus(1'b1, r*32 + 4, 4, 32'd0, rd, err);
      chk(!err, "R4 discarded write no error", {63'd0, err}, 64'd0);
      bus(1'b1, r*32 + 8, 4, 32'hFFFF_FFFF, rd, err);
      repeat (12) @(negedge clk);
      chk(pulses == 0, "R4 no launch", 64'(pulses), 64'd0);
      bus(1'b0, r*32 + 4, 4, 32'd0, rd, err);
      chk(rd == model_rd(r*32 + 4, 4), "R4 hold word unchanged", 64'(rd), model_rd(r*32 + 4, 4));
      bus(1'b0, r*32 + 8, 4, 32'd0, rd, err);
      chk(rd == model_rd(r*32 + 8, 4), "R4 arg unchanged", 64'(rd), model_rd(r*32 + 8, 4));
    end

    // R5: illegal sizes and misalignment
    for (int sz = 0; sz < 8; sz++) begin
      if (sz == 1 || sz == 2 || sz == 4) continue;
      pulses = 0;
      bus(1'b1, 32 + 4, sz, 32'd0, rd, err);
      chk(err, "R5 bad size error", {63'd0, err}, 64'd1);
      repeat (12) @(negedge clk);
      chk(pulses == 0, "R5 bad size no launch", 64'(pulses), 64'd0);
      bus(1'b0, 32 + 4, 4, 32'd0, rd, err);
      chk(rd == 32'd1, "R5 storage unchanged", 64'(rd), 64'd1);
    end
    bus(1'b1, 32 + 5, 2, 32'd0, rd, err);
    chk(err, "R5 misaligned halfword", {63'd0, err}, 64'd1);
    bus(1'b1, 32 + 6, 4, 32'd0, rd, err);
    chk(err, "R5 misaligned word", {63'd0, err}, 64'd1);
    bus(1'b0, 32 + 6, 4, 32'd0, rd, err);
    chk(err, "R5 misaligned read", {63'd0, err}, 64'd1);
    bus(1'b0, 32 + 4, 4, 32'd0, rd, err);
    chk(rd == 32'd1, "R5 hold kept after misaligned", 64'(rd), 64'd1);

    // R6 R7 R8: releases through word, byte and halfword writes
    wr_watch(32 + 8, 4, 32'h0000_00AB, 1'b0, "R6 arg hi");
    wr_watch(32 + 12, 4, 32'hCDEF_0123, 1'b0, "R6 arg lo");
    wr_watch(32 + 0, 4, 32'h0000_0001, 1'b0, "R6 addr hi");
    wr_watch(32 + 4, 4, 32'h1ABC_DEF0, 1'b1, "R6 word release");
    wr_watch(64 + 7, 1, 32'h0000_0042, 1'b1, "R6 byte release");
    wr_watch(96 + 6, 2, 32'h7FFE_7FFE, 1'b1, "R6 halfword release");

    // R9: no second launch
    wr_watch(32 + 4, 4, 32'h0000_0011, 1'b0, "R9 set hold");
    wr_watch(32 + 4, 4, 32'h0000_0010, 1'b0, "R9 clear again");
    wr_watch(64 + 7, 1, 32'h0000_0000, 1'b0, "R9 core2 repeat");

    // R9: reset re-arms
    do_reset();
    bus(1'b0, 32 + 20, 4, 32'd0, rd, err);
    chk(rd == 32'd1, "R1 core id restored", 64'(rd), 64'd1);
    bus(1'b0, 32 + 4, 4, 32'd0, rd, err);
    chk(rd == 32'd1, "R1 hold restored", 64'(rd), 64'd1);
    wr_watch(32 + 4, 4, 32'h0400_0000, 1'b1, "R9 rearm");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule